// File: doc/BRIEF.md
# Rectangular Window Write Sequencer

This block takes 16-bit words arriving at a display memory data port and steers them into a frame buffer, one word per accepted transfer, inside a rectangular window. Inclusive start and end corners set the window, and a pixel format code sets the bytes per pixel. When a transfer is armed, the block works out the window span and how many bus words will fill it. It then issues one frame buffer write per accepted word, at a linear address, and raises a one-cycle done pulse after the last word.

A transfer is armed in one of two ways. The first is a strobe that goes with a write of the source selector. The second is automatic: a data word that arrives while nothing is pending arms the transfer and is itself the first word of the window. A dirty rectangle gathers the bounding box of every finished window, so the refresh side knows what to repaint. The refresh side can empty the rectangle once it has used it, or force it to cover the whole panel.

Top module: `wwin_seq`

## Requirements
- R1: After reset no transfer is pending, `done` is low, and the dirty box is empty: min X equals PANEL_W, min Y equals PANEL_H, and both max values are 0.
- R2: A configuration is valid only if `srcSel` is 3 or less, the format has a nonzero byte count, `endX` >= `startX` and `endY` >= `startY`. An arm strobe with an invalid configuration leaves the block unchanged. A word that arrives while idle with an invalid configuration is accepted and dropped, with no frame buffer write.
- R3: Format code to bytes per pixel: code 1 gives 2, codes 2 and 3 give 3, codes 6 and 7 give 4, and every other code gives 0.
- R4: The word count is floor(bytes x (endX-startX+1) x (endY-startY+1) / 2). `done` is high for exactly the one cycle after the edge that accepts the last word.
- R5: The write address is row x PANEL_W + column. The first word goes to (startX, startY). The column steps by one up to endX, then goes back to startX on the next row. After endY the row goes back to startY.
- R6: A word accepted while idle with a valid configuration arms the transfer, latches the window and is written at the start address in the same cycle. `fbData` always carries `wordData`.
- R7: An arm strobe with a valid configuration reloads the full word count and the start position, which abandons any transfer in progress. `wordReady` is low in every cycle in which `armStrobe` is high.
- R8: `wordReady` follows `fbReady`, except as R7 states. A word is taken only when `wordValid` and `wordReady` are both high, and `fbWrEn` is never high while `fbReady` is low.
- R9: On the edge that ends the `done` cycle, the dirty box grows to min X = min(minX, startX), min Y = min(minY, startY), max X = max(maxX, endX+1) and max Y = max(maxY, endY+1), using the window of the finished transfer.
- R10: A `clearBox` pulse empties the dirty box as in R1 on the next edge. It takes priority over a growth from R9 on the same edge.
- R11: An `invalidate` pulse sets the box to (0,0)-(PANEL_W,PANEL_H) on the next edge. It takes priority over both clearing and growth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startX | input | COORD_W | Window first column |
| startY | input | COORD_W | Window first row |
| endX | input | COORD_W | Window last column, inclusive |
| endY | input | COORD_W | Window last row, inclusive |
| fmtCode | input | 4 | Pixel format code |
| srcSel | input | 3 | Source selector value |
| armStrobe | input | 1 | Source selector write, arms a transfer |
| wordValid | input | 1 | Data word present |
| wordData | input | 16 | Data word |
| wordReady | output | 1 | Data word taken this cycle when valid |
| fbReady | input | 1 | Frame buffer can take a write |
| fbWrEn | output | 1 | Frame buffer write strobe |
| fbAddr | output | ADDR_W | Frame buffer word address |
| fbData | output | 16 | Frame buffer write data |
| done | output | 1 | Window filled, one-cycle pulse |
| clearBox | input | 1 | Empty the dirty box |
| invalidate | input | 1 | Set the dirty box to the full panel |
| dirtyMinX | output | COORD_W+1 | Dirty box left edge |
| dirtyMinY | output | COORD_W+1 | Dirty box top edge |
| dirtyMaxX | output | COORD_W+1 | Dirty box right edge, exclusive |
| dirtyMaxY | output | COORD_W+1 | Dirty box bottom edge, exclusive |

## Verification
A model in the bench is compared with the design on every clock. The stimulus uses a multi-row window at 2 bytes per pixel with a stalling frame buffer, which separates the count from the address raster and checks back-pressure. It also uses a single-column window at 3 bytes per pixel, where the count exceeds the pixel count and the address wraps back to the window start, and one-pixel windows at 3 and 4 bytes per pixel, which test the rounding down of the count and a done after a single word. Invalid selector, invalid format and reversed corners check that words are dropped. A re-arm in the middle of a transfer, and clear or invalidate pulses that land on the growth edge, check the priority order.

// File: rtl/wwin_pkg.sv
package wwin_pkg;
  // Strobes from control to datapath.
  typedef struct packed {
    logic arm;        // reload from the arm strobe
    logic firstWord;  // idle word that arms the transfer itself
    logic nextWord;   // word inside a running transfer
    logic commit;     // grow the dirty box with the latched window
    logic boxClear;   // empty the dirty box
    logic boxFull;    // dirty box covers the panel
  } wwin_ctrl_t;

  function automatic logic [2:0] bytesPerPixel(input logic [3:0] fmt);
    case (fmt)
      4'd1:       return 3'd2;
      4'd2, 4'd3: return 3'd3;
      4'd6, 4'd7: return 3'd4;
      default:    return 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/wwin_ctrl.sv
module wwin_ctrl
  import wwin_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       armStrobe,
  input  logic       wordValid,
  input  logic       fbReady,
  input  logic       clearBox,
  input  logic       invalidate,
  input  logic       cfgOk,
  input  logic       busy,
  input  logic       lastWord,
  input  logic       firstIsLast,
  output wwin_ctrl_t ctrl,
  output logic       wordReady,
  output logic       fbWrEn,
  output logic       done
);
  logic accept;
  logic doneQ;

  assign wordReady = fbReady & ~armStrobe;
  assign accept    = wordValid & wordReady;

  always_comb begin
    ctrl           = '0;
    ctrl.arm       = armStrobe & cfgOk;
    ctrl.firstWord = accept & ~busy & cfgOk;
    ctrl.nextWord  = accept & busy;
    ctrl.commit    = doneQ;
    ctrl.boxFull   = invalidate;
    ctrl.boxClear  = clearBox & ~invalidate;
  end

  assign fbWrEn = ctrl.firstWord | ctrl.nextWord;
  assign done   = doneQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) doneQ <= 1'b0;
    else       doneQ <= (ctrl.nextWord & lastWord) | (ctrl.firstWord & firstIsLast);
  end
endmodule

// File: rtl/wwin_datapath.sv
module wwin_datapath
  import wwin_pkg::*;
#(
  parameter int PANEL_W = 320,
  parameter int PANEL_H = 240,
  parameter int COORD_W = 10,
  parameter int ADDR_W  = $clog2(PANEL_W * PANEL_H)
) (
  input  logic               clk,
  input  logic               rstN,
  input  wwin_ctrl_t         ctrl,
  input  logic [COORD_W-1:0] startX,
  input  logic [COORD_W-1:0] startY,
  input  logic [COORD_W-1:0] endX,
  input  logic [COORD_W-1:0] endY,
  input  logic [3:0]         fmtCode,
  input  logic [2:0]         srcSel,
  output logic               cfgOk,
  output logic               busy,
  output logic               lastWord,
  output logic               firstIsLast,
  output logic [ADDR_W-1:0]  fbAddr,
  output logic [COORD_W:0]   dirtyMinX,
  output logic [COORD_W:0]   dirtyMinY,
  output logic [COORD_W:0]   dirtyMaxX,
  output logic [COORD_W:0]   dirtyMaxY
);
  localparam int SPAN_W = COORD_W + 1;
  localparam int CNT_W  = 2 * SPAN_W + 3;
  localparam logic [SPAN_W-1:0] PW_B = SPAN_W'(PANEL_W);
  localparam logic [SPAN_W-1:0] PH_B = SPAN_W'(PANEL_H);

  logic [2:0]         bpp;
  logic [SPAN_W-1:0]  spanX, spanY;
  logic [CNT_W-1:0]   total, remaining;
  logic [COORD_W-1:0] colQ, rowQ, x0q, x1q, y0q, y1q;
  logic [COORD_W-1:0] curCol, curRow, loX, hiX, loY, hiY, nxtCol, nxtRow;

  assign bpp   = bytesPerPixel(fmtCode);
  assign cfgOk = (srcSel <= 3'd3) && (bpp != 3'd0) && (endX >= startX) && (endY >= startY);
  assign spanX = ({1'b0, endX} - {1'b0, startX}) + SPAN_W'(1);
  assign spanY = ({1'b0, endY} - {1'b0, startY}) + SPAN_W'(1);
  assign total = (CNT_W'(bpp) * CNT_W'(spanX) * CNT_W'(spanY)) >> 1;

  assign busy        = remaining != '0;
  assign lastWord    = remaining == CNT_W'(1);
  assign firstIsLast = total == CNT_W'(1);

  // Position of the word on the port: running position, else the live start.
  always_comb begin
    curCol = busy ? colQ : startX;
    curRow = busy ? rowQ : startY;
    loX    = busy ? x0q  : startX;
    hiX    = busy ? x1q  : endX;
    loY    = busy ? y0q  : startY;
    hiY    = busy ? y1q  : endY;
    nxtCol = (curCol == hiX) ? loX : curCol + 1'b1;
    nxtRow = (curCol != hiX) ? curRow : ((curRow == hiY) ? loY : curRow + 1'b1);
  end

  assign fbAddr = ADDR_W'(curRow) * ADDR_W'(PANEL_W) + ADDR_W'(curCol);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remaining <= '0;
      colQ <= '0; rowQ <= '0;
      x0q  <= '0; x1q  <= '0; y0q <= '0; y1q <= '0;
    end else if (ctrl.arm || ctrl.firstWord) begin
      x0q <= startX; x1q <= endX; y0q <= startY; y1q <= endY;
      if (ctrl.arm) begin
        remaining <= total;
        colQ <= startX; rowQ <= startY;
      end else begin
        remaining <= total - CNT_W'(1);
        colQ <= nxtCol; rowQ <= nxtRow;
      end
    end else if (ctrl.nextWord) begin
      remaining <= remaining - CNT_W'(1);
      colQ <= nxtCol; rowQ <= nxtRow;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirtyMinX <= PW_B; dirtyMinY <= PH_B; dirtyMaxX <= '0; dirtyMaxY <= '0;
    end else if (ctrl.boxFull) begin
      dirtyMinX <= '0; dirtyMinY <= '0; dirtyMaxX <= PW_B; dirtyMaxY <= PH_B;
    end else if (ctrl.boxClear) begin
      dirtyMinX <= PW_B; dirtyMinY <= PH_B; dirtyMaxX <= '0; dirtyMaxY <= '0;
    end else if (ctrl.commit) begin
      if ({1'b0, x0q} < dirtyMinX) dirtyMinX <= {1'b0, x0q};
      if ({1'b0, y0q} < dirtyMinY) dirtyMinY <= {1'b0, y0q};
      if ({1'b0, x1q} + SPAN_W'(1) > dirtyMaxX) dirtyMaxX <= {1'b0, x1q} + SPAN_W'(1);
      if ({1'b0, y1q} + SPAN_W'(1) > dirtyMaxY) dirtyMaxY <= {1'b0, y1q} + SPAN_W'(1);
    end
  end
endmodule

// File: rtl/wwin_seq.sv
module wwin_seq
  import wwin_pkg::*;
#(
  parameter int PANEL_W = 320,
  parameter int PANEL_H = 240,
  parameter int COORD_W = 10,
  parameter int ADDR_W  = $clog2(PANEL_W * PANEL_H)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [COORD_W-1:0] startX,
  input  logic [COORD_W-1:0] startY,
  input  logic [COORD_W-1:0] endX,
  input  logic [COORD_W-1:0] endY,
  input  logic [3:0]         fmtCode,
  input  logic [2:0]         srcSel,
  input  logic               armStrobe,
  input  logic               wordValid,
  input  logic [15:0]        wordData,
  output logic               wordReady,
  input  logic               fbReady,
  output logic               fbWrEn,
  output logic [ADDR_W-1:0]  fbAddr,
  output logic [15:0]        fbData,
  output logic               done,
  input  logic               clearBox,
  input  logic               invalidate,
  output logic [COORD_W:0]   dirtyMinX,
  output logic [COORD_W:0]   dirtyMinY,
  output logic [COORD_W:0]   dirtyMaxX,
  output logic [COORD_W:0]   dirtyMaxY
);
  wwin_ctrl_t ctrl;
  logic cfgOk, busy, lastWord, firstIsLast;

  assign fbData = wordData;

  wwin_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .armStrobe(armStrobe), .wordValid(wordValid),
    .fbReady(fbReady), .clearBox(clearBox), .invalidate(invalidate),
    .cfgOk(cfgOk), .busy(busy), .lastWord(lastWord), .firstIsLast(firstIsLast),
    .ctrl(ctrl), .wordReady(wordReady), .fbWrEn(fbWrEn), .done(done)
  );

  wwin_datapath #(.PANEL_W(PANEL_W), .PANEL_H(PANEL_H), .COORD_W(COORD_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .startX(startX), .startY(startY), .endX(endX), .endY(endY),
    .fmtCode(fmtCode), .srcSel(srcSel),
    .cfgOk(cfgOk), .busy(busy), .lastWord(lastWord), .firstIsLast(firstIsLast),
    .fbAddr(fbAddr),
    .dirtyMinX(dirtyMinX), .dirtyMinY(dirtyMinY), .dirtyMaxX(dirtyMaxX), .dirtyMaxY(dirtyMaxY)
  );
endmodule

// File: rtl/wwin_seq_chk.sv
module wwin_seq_chk #(
  parameter int PANEL_W = 320,
  parameter int PANEL_H = 240,
  parameter int COORD_W = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic             armStrobe,
  input logic             wordReady,
  input logic             fbReady,
  input logic             fbWrEn,
  input logic             done,
  input logic             clearBox,
  input logic             invalidate,
  input logic [COORD_W:0] dirtyMinX,
  input logic [COORD_W:0] dirtyMinY,
  input logic [COORD_W:0] dirtyMaxX,
  input logic [COORD_W:0] dirtyMaxY
);
  AST_WRITE_NEEDS_READY: assert property (@(posedge clk) disable iff (!rstN)
    fbWrEn |-> fbReady); // R8
  AST_ARM_STALLS_WORDS: assert property (@(posedge clk) disable iff (!rstN)
    armStrobe |-> !wordReady); // R7
  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(fbWrEn)); // R4
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    (clearBox && !invalidate) |=> (dirtyMinX == (COORD_W+1)'(PANEL_W) && dirtyMinY == (COORD_W+1)'(PANEL_H)
                                   && dirtyMaxX == '0 && dirtyMaxY == '0)); // R10
  AST_INVALIDATE_FULL: assert property (@(posedge clk) disable iff (!rstN)
    invalidate |=> (dirtyMinX == '0 && dirtyMinY == '0 && dirtyMaxX == (COORD_W+1)'(PANEL_W)
                    && dirtyMaxY == (COORD_W+1)'(PANEL_H))); // R11
endmodule

bind wwin_seq wwin_seq_chk #(.PANEL_W(PANEL_W), .PANEL_H(PANEL_H), .COORD_W(COORD_W)) u_chk (
  .clk(clk), .rstN(rstN), .armStrobe(armStrobe), .wordReady(wordReady), .fbReady(fbReady),
  .fbWrEn(fbWrEn), .done(done), .clearBox(clearBox), .invalidate(invalidate),
  .dirtyMinX(dirtyMinX), .dirtyMinY(dirtyMinY), .dirtyMaxX(dirtyMaxX), .dirtyMaxY(dirtyMaxY)
);

// File: tb/tb_wwin_seq.sv
`timescale 1ns/1ps
module tb_wwin_seq;
  localparam int PW = 320, PH = 240, CW = 10, AW = $clog2(PW * PH);

  logic clk = 1'b0, rstN = 1'b0;
  logic [CW-1:0] startX = '0, startY = '0, endX = '0, endY = '0;
  logic [3:0] fmtCode = 4'd1;
  logic [2:0] srcSel = 3'd0;
  logic armStrobe = 1'b0, wordValid = 1'b0, fbReady = 1'b1, clearBox = 1'b0, invalidate = 1'b0;
  logic [15:0] wordData = 16'h0;
  logic wordReady, fbWrEn, done;
  logic [AW-1:0] fbAddr;
  logic [15:0] fbData;
  logic [CW:0] dirtyMinX, dirtyMinY, dirtyMaxX, dirtyMaxY;

  always #4 clk = ~clk; // 125 MHz

  wwin_seq #(.PANEL_W(PW), .PANEL_H(PH), .COORD_W(CW)) dut (.*);

  int checks = 0, errors = 0;
  string phase = "R1";

  // Behavioural model state
  int mRem = 0, mCol = 0, mRow = 0, mX0 = 0, mX1 = 0, mY0 = 0, mY1 = 0;
  int mDone = 0, accCnt = 0;
  int bMinX = PW, bMinY = PH, bMaxX = 0, bMaxY = 0;

  function automatic int bppOf(input int f);
    if (f == 1) return 2;
    if (f == 2 || f == 3) return 3;
    if (f == 6 || f == 7) return 4;
    return 0;
  endfunction

  function automatic bit cfgValid();
    return srcSel <= 3 && bppOf(fmtCode) != 0 && endX >= startX && endY >= startY;
  endfunction

  function automatic int totalWords();
    return (bppOf(fmtCode) * (int'(endX) - int'(startX) + 1) * (int'(endY) - int'(startY) + 1)) / 2;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s (phase %s) at %0t: actual %0d expected %0d", tag, phase, $time, act, exp);
    end
  endtask

  task automatic advance();
    if (mCol == mX1) begin
      mCol = mX0;
      mRow = (mRow == mY1) ? mY0 : mRow + 1;
    end else mCol = mCol + 1;
  endtask

  always @(posedge clk) begin
    bit ready, acc, ok;
    int newDone;
    ok = cfgValid();
    ready = fbReady && !armStrobe;
    acc = wordValid && ready;
    newDone = 0;
    if (!rstN) begin
      mRem = 0; mDone = 0; bMinX = PW; bMinY = PH; bMaxX = 0; bMaxY = 0;
    end else begin
      if (invalidate) begin bMinX = 0; bMinY = 0; bMaxX = PW; bMaxY = PH; end
      else if (clearBox) begin bMinX = PW; bMinY = PH; bMaxX = 0; bMaxY = 0; end
      else if (mDone != 0) begin
        if (mX0 < bMinX) bMinX = mX0;
        if (mY0 < bMinY) bMinY = mY0;
        if (mX1 + 1 > bMaxX) bMaxX = mX1 + 1;
        if (mY1 + 1 > bMaxY) bMaxY = mY1 + 1;
      end
      if (armStrobe) begin
        if (ok) begin
          mRem = totalWords(); mX0 = startX; mX1 = endX; mY0 = startY; mY1 = endY;
          mCol = mX0; mRow = mY0;
        end
      end else if (acc) begin
        accCnt++;
        if (mRem > 0) begin
          advance(); mRem--; if (mRem == 0) newDone = 1;
        end else if (ok) begin
          mX0 = startX; mX1 = endX; mY0 = startY; mY1 = endY; mCol = mX0; mRow = mY0;
          advance(); mRem = totalWords() - 1; if (mRem == 0) newDone = 1;
        end
      end
      mDone = newDone;
    end
    #2;
    begin
      bit eReady, eWr;
      int eAddr;
      eReady = fbReady && !armStrobe;
      eWr = rstN && wordValid && eReady && (mRem > 0 || cfgValid());
      eAddr = (mRem > 0) ? mRow * PW + mCol : int'(startY) * PW + int'(startX);
      chk("R8 wordReady", int'(wordReady), int'(eReady));
      chk("R6 fbWrEn", int'(fbWrEn), int'(eWr));
      if (eWr) begin
        chk("R5 fbAddr", int'(fbAddr), eAddr);
        chk("R6 fbData", int'(fbData), int'(wordData));
      end
      chk("R4 done", int'(done), mDone);
      chk("R9 minX", int'(dirtyMinX), bMinX);
      chk("R9 minY", int'(dirtyMinY), bMinY);
      chk("R9 maxX", int'(dirtyMaxX), bMaxX);
      chk("R9 maxY", int'(dirtyMaxY), bMaxY);
    end
  end

  task automatic setWin(input int sx, input int sy, input int ex, input int ey, input int f, input int s);
    @(negedge clk);
    startX = CW'(sx); startY = CW'(sy); endX = CW'(ex); endY = CW'(ey);
    fmtCode = 4'(f); srcSel = 3'(s);
  endtask

  task automatic armIt();
    @(negedge clk); armStrobe = 1'b1;
    @(negedge clk); armStrobe = 1'b0;
  endtask

  // Push until n words are taken; frame buffer stalls on one cycle in three when stall set.
  task automatic sendWords(input int n, input bit stall);
    int base = accCnt;
    int k = 0;
    @(negedge clk);
    wordValid = 1'b1;
    while (accCnt - base < n) begin
      fbReady = stall ? (k % 3 != 2) : 1'b1;
      wordData = wordData + 16'h0101;
      k++;
      @(negedge clk);
    end
    wordValid = 1'b0; fbReady = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    idle(2);                                   // R1 reset state compared every clock
    phase = "R4";                              // R3 code 1 -> 2 bytes, 3x2 window, 6 words, stalls R8
    setWin(2, 3, 4, 4, 1, 0); armIt(); sendWords(6, 1'b1); idle(3);
    phase = "R5";                              // R3 code 3 -> 3 bytes, 1x2 column, 3 words, auto arm R6
    setWin(10, 1, 10, 2, 3, 2); sendWords(3, 1'b0); idle(3);
    phase = "R2";                              // invalid: selector, format, reversed corners
    setWin(0, 0, 1, 1, 1, 5); armIt(); sendWords(2, 1'b0); idle(2);
    setWin(0, 0, 1, 1, 4, 0); armIt(); sendWords(2, 1'b0); idle(2);
    setWin(5, 0, 4, 1, 1, 0); sendWords(1, 1'b0); idle(2);
    setWin(0, 5, 1, 4, 7, 1); sendWords(1, 1'b0); idle(2);
    phase = "R3";                              // code 7 -> 4 bytes, 1x1 gives 2; code 2 gives floor(3/2)=1
    setWin(20, 30, 20, 30, 7, 0); sendWords(2, 1'b0); idle(2);
    setWin(40, 50, 40, 50, 2, 0); sendWords(1, 1'b0); sendWords(1, 1'b0); idle(2);
    phase = "R7";                              // re-arm mid transfer restarts at start
    setWin(6, 6, 9, 7, 1, 0); armIt(); sendWords(3, 1'b0);
    setWin(100, 100, 101, 100, 6, 1);
    @(negedge clk); armStrobe = 1'b1; wordValid = 1'b1;
    @(negedge clk); armStrobe = 1'b0; wordValid = 1'b0;
    sendWords(4, 1'b1); idle(3);
    phase = "R10";                             // clear on the growth edge wins
    clearBox = 1'b1; @(negedge clk); clearBox = 1'b0; idle(1);
    setWin(7, 8, 9, 8, 1, 0); sendWords(3, 1'b0);
    clearBox = 1'b1; @(negedge clk); clearBox = 1'b0; idle(2);
    phase = "R11";                             // invalidate beats clear and growth
    setWin(1, 1, 1, 1, 1, 0); sendWords(1, 1'b0);
    invalidate = 1'b1; clearBox = 1'b1; @(negedge clk); invalidate = 1'b0; clearBox = 1'b0; idle(2);
    phase = "R9";
    clearBox = 1'b1; @(negedge clk); clearBox = 1'b0;
    setWin(300, 230, 319, 239, 1, 3); sendWords(200, 1'b1); idle(3);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (phase %s): actual timeout expected finish", phase);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule